// File: doc/BRIEF.md
# Lane Code-Group Synchronization Machine

This block watches the decoded code-group stream of one receive lane of an 8b/10b four-lane link. From that stream it decides whether the lane is synchronized. Each accepted code group comes with three things: an 8-bit value, a control flag, and an invalid flag raised by the decoder upstream. The block drives one registered status bit. The link layer reads that bit, and the multi-lane deskew logic waits for it on every lane before it starts.

Three states carry the decision. `S_HUNT` means no comma has been counted yet. `S_ACQ` means one or more error-free commas have been counted but not yet enough. `S_LOCK` means the lane is synchronized.

The transitions are:
- **hunt→acq**: on the first comma.
- **acq→acq**: a comma advances the count.
- **acq→hunt**: an invalid group clears the count.
- **acq→lock**: the fourth comma arrives.
- **lock→hunt**: the error level reaches its limit.

While in `S_LOCK`, an error tracker keeps an error level. Each invalid group raises the level by one. Each run of four consecutive valid groups lowers it by one. When the level reaches four, sync is lost.

Top module: `lane_sync_fsm`

## Requirements
- R1: A comma is a group whose value is 0xBC with the control flag set. Sync status rises once four commas have been accepted with no invalid group between them. Fewer commas leave it low.
- R2: Sync status is registered. It is high after the clock edge that accepts the fourth comma, and low in every cycle in which the lane is not synchronized.
- R3: During acquisition, an accepted invalid group clears the comma count to zero.
- R4: During acquisition, valid non-comma groups neither advance nor clear the comma count. This includes 0xBC without the control flag, and other control values.
- R5: A group with the invalid flag set counts as invalid even when its value and control flag form a comma.
- R6: While synchronized, four invalid groups with fewer than four valid groups between each one and the next drop sync status low after the edge that accepts the fourth.
- R7: While synchronized, each run of four consecutive valid groups lowers the error level by one, down to zero. An invalid group followed by four valid groups, repeated any number of times, therefore keeps sync.
- R8: After sync is lost, acquisition restarts from a count of zero, so four new commas are needed.
- R9: Cycles without the valid strobe change neither the status nor the internal counts, whatever the data and flag inputs carry.
- R10: Reset drives sync status low and clears the comma count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_valid_i | input | 1 | Strobe: a code group is presented this cycle |
| cg_data_i | input | 8 | Decoded code-group value |
| cg_ctrl_i | input | 1 | Control flag of the group |
| cg_bad_i | input | 1 | Invalid flag from the decoder |
| sync_o | output | 1 | Lane synchronized status, registered |

## Verification
The error level inside `S_LOCK` is the hardest state to reach and to observe. Only its end effect shows at the port, when sync drops.

The bench first locks the lane. It then spaces invalid groups with exactly three valid groups between them, which must reach the limit. It also spaces them with exactly four, which must never reach it.

A mixed pattern builds the level to three, drains it with twelve valid groups, and adds three invalid groups again. This shows that draining reaches zero and does not go below it. One further invalid group then drops sync.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_ACQ  = 2'd1,
        S_LOCK = 2'd2
    } lsm_state_t;

    localparam logic [7:0] COMMA_VALUE = 8'hBC;
endpackage

// File: rtl/lsm_cg_classify.sv
module lsm_cg_classify
    import lsm_pkg::*;
(
    input  logic [7:0] data_i,
    input  logic       ctrl_i,
    input  logic       bad_i,
    output logic       is_comma_o,
    output logic       is_bad_o
);
    // R5: the invalid flag overrides comma recognition
    assign is_bad_o   = bad_i;
    assign is_comma_o = ctrl_i && (data_i == COMMA_VALUE) && !bad_i;
endmodule

// File: rtl/lsm_err_tracker.sv
module lsm_err_tracker #(
    parameter int ERR_LIMIT = 4,
    parameter int GOOD_RUN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_lock_i,
    input  logic step_i,
    input  logic bad_i,
    output logic trip_o
);
    localparam int EW = $clog2(ERR_LIMIT + 1);
    localparam int GW = $clog2(GOOD_RUN + 1);

    logic [EW-1:0] lvl_q;
    logic [GW-1:0] good_q;

    assign trip_o = step_i && bad_i && (lvl_q == EW'(ERR_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !in_lock_i || trip_o) begin
            lvl_q  <= '0;
            good_q <= '0;
        end else if (step_i) begin
            if (bad_i) begin
                lvl_q  <= lvl_q + 1'b1;
                good_q <= '0;
            end else if (lvl_q != '0) begin
                if (good_q == GW'(GOOD_RUN - 1)) begin
                    lvl_q  <= lvl_q - 1'b1;
                    good_q <= '0;
                end else begin
                    good_q <= good_q + 1'b1;
                end
            end
        end
    end

    // R6: an invalid group below the limit raises the level by one
    p_err_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lock_i && step_i && bad_i && !trip_o) |=> lvl_q == $past(lvl_q) + 1'b1);

    // R7: a full run of valid groups lowers the level by one
    p_err_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lock_i && step_i && !bad_i && lvl_q != '0 && good_q == GW'(GOOD_RUN - 1))
        |=> lvl_q == $past(lvl_q) - 1'b1);
endmodule

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm
    import lsm_pkg::*;
#(
    parameter int N_COMMA   = 4,
    parameter int ERR_LIMIT = 4,
    parameter int GOOD_RUN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cg_valid_i,
    input  logic [7:0] cg_data_i,
    input  logic       cg_ctrl_i,
    input  logic       cg_bad_i,
    output logic       sync_o
);
    localparam int CW = $clog2(N_COMMA + 1);

    lsm_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          is_comma, is_bad, trip, in_lock, step;

    lsm_cg_classify u_cls (
        .data_i     (cg_data_i),
        .ctrl_i     (cg_ctrl_i),
        .bad_i      (cg_bad_i),
        .is_comma_o (is_comma),
        .is_bad_o   (is_bad)
    );

    assign in_lock = (state_q == S_LOCK);
    assign step    = cg_valid_i && in_lock;

    lsm_err_tracker #(.ERR_LIMIT(ERR_LIMIT), .GOOD_RUN(GOOD_RUN)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_lock_i (in_lock),
        .step_i    (step),
        .bad_i     (is_bad),
        .trip_o    (trip)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cg_valid_i) begin
            unique case (state_q)
                S_HUNT: begin
                    if (is_comma) begin
                        cnt_d   = (N_COMMA == 1) ? '0 : CW'(1);
                        state_d = (N_COMMA == 1) ? S_LOCK : S_ACQ;
                    end
                end
                S_ACQ: begin
                    if (is_bad) begin
                        cnt_d   = '0;
                        state_d = S_HUNT;
                    end else if (is_comma) begin
                        if (cnt_q == CW'(N_COMMA - 1)) begin
                            cnt_d   = '0;
                            state_d = S_LOCK;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                S_LOCK: begin
                    if (trip) begin
                        cnt_d   = '0;
                        state_d = S_HUNT;
                    end
                end
                default: begin
                    cnt_d   = '0;
                    state_d = S_HUNT;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) sync_o <= 1'b0;
        else        sync_o <= (state_d == S_LOCK);
    end

    p_sync_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(cg_valid_i && is_comma));

    p_sync_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o == (state_q == S_LOCK));

    p_acq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_valid_i && is_bad && state_q != S_LOCK) |=> (cnt_q == '0 && !sync_o));

    p_noncomma_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_valid_i && !is_bad && !is_comma && state_q == S_ACQ) |=> $stable(cnt_q));

    p_trip_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (!sync_o && cnt_q == '0));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cg_valid_i |=> ($stable(sync_o) && $stable(cnt_q)));
endmodule

// File: tb/lane_sync_fsm_bench.sv
module lane_sync_fsm_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cg_valid_i = 1'b0;
    logic [7:0] cg_data_i = 8'h00;
    logic       cg_ctrl_i = 1'b0;
    logic       cg_bad_i = 1'b0;
    logic       sync_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lane_sync_fsm u_lane_sync_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cg_valid_i (cg_valid_i),
        .cg_data_i  (cg_data_i),
        .cg_ctrl_i  (cg_ctrl_i),
        .cg_bad_i   (cg_bad_i),
        .sync_o     (sync_o)
    );

    task automatic chk(input string req, input logic exp);
        n_checks++;
        if (sync_o !== exp) begin
            n_errors++;
            $display("FAIL %s: sync_o=%b expected %b", req, sync_o, exp);
        end
    endtask

    // present one group, return at the falling edge after it is accepted
    task automatic send(input logic [7:0] d, input logic c, input logic b);
        @(negedge clk);
        cg_valid_i = 1'b1; cg_data_i = d; cg_ctrl_i = c; cg_bad_i = b;
        @(negedge clk);
        cg_valid_i = 1'b0; cg_bad_i = 1'b0;
    endtask

    task automatic comma();    send(8'hBC, 1'b1, 1'b0); endtask
    task automatic good();     send(8'h4A, 1'b0, 1'b0); endtask
    task automatic bad();      send(8'h4A, 1'b0, 1'b1); endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic lock_up();
        do_reset();
        for (int i = 0; i < 4; i++) comma();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10 reset state", 1'b0);
    endtask

    task automatic t_acquire();
        do_reset();
        for (int i = 0; i < 3; i++) comma();
        chk("R1 three commas", 1'b0);
        comma();
        chk("R2 fourth comma", 1'b1);
    endtask

    task automatic t_acq_invalid();
        do_reset();
        for (int i = 0; i < 3; i++) comma();
        bad();
        for (int i = 0; i < 3; i++) comma();
        chk("R3 count cleared", 1'b0);
        comma();
        chk("R3 fourth after clear", 1'b1);
    endtask

    task automatic t_acq_noncomma();
        do_reset();
        comma(); comma();
        send(8'h50, 1'b0, 1'b0);
        send(8'hBC, 1'b0, 1'b0);
        send(8'h1C, 1'b1, 1'b0);
        comma();
        chk("R4 non-comma not counted", 1'b0);
        comma();
        chk("R4 non-comma not cleared", 1'b1);
    endtask

    task automatic t_bad_comma();
        do_reset();
        for (int i = 0; i < 3; i++) comma();
        send(8'hBC, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) comma();
        chk("R5 invalid comma clears", 1'b0);
    endtask

    task automatic t_loss();
        lock_up();
        for (int k = 0; k < 3; k++) begin
            bad();
            for (int i = 0; i < 3; i++) good();
        end
        chk("R6 three errors held", 1'b1);
        bad();
        chk("R6 fourth error drops", 1'b0);
    endtask

    task automatic t_hysteresis();
        lock_up();
        for (int k = 0; k < 6; k++) begin
            bad();
            for (int i = 0; i < 4; i++) good();
        end
        chk("R7 spaced errors keep sync", 1'b1);
        lock_up();
        for (int i = 0; i < 3; i++) bad();
        for (int i = 0; i < 12; i++) good();
        for (int i = 0; i < 3; i++) bad();
        chk("R7 drained to zero", 1'b1);
        bad();
        chk("R7 limit after drain", 1'b0);
    endtask

    task automatic t_reacquire();
        lock_up();
        for (int i = 0; i < 4; i++) bad();
        for (int i = 0; i < 3; i++) comma();
        chk("R8 restart from zero", 1'b0);
        comma();
        chk("R8 relock", 1'b1);
    endtask

    task automatic t_idle();
        lock_up();
        @(negedge clk);
        cg_valid_i = 1'b0; cg_bad_i = 1'b1; cg_data_i = 8'hFF;
        repeat (10) @(negedge clk);
        cg_bad_i = 1'b0;
        chk("R9 idle in lock", 1'b1);
        do_reset();
        for (int i = 0; i < 3; i++) comma();
        @(negedge clk);
        cg_bad_i = 1'b1;
        repeat (5) @(negedge clk);
        cg_bad_i = 1'b0;
        chk("R9 idle in acq", 1'b0);
        comma();
        chk("R9 count kept over idle", 1'b1);
    endtask

    task automatic t_reset_mid();
        lock_up();
        do_reset();
        chk("R10 reset drops sync", 1'b0);
        comma(); comma();
        do_reset();
        comma(); comma();
        chk("R10 count cleared", 1'b0);
        comma(); comma();
        chk("R10 fresh lock", 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_acquire();
        t_acq_invalid();
        t_acq_noncomma();
        t_bad_comma();
        t_loss();
        t_hysteresis();
        t_reacquire();
        t_idle();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule